// File: doc/BRIEF.md
# NAND Page Column to Buffer Address Mapper

This block turns a run of byte columns within a NAND page into the byte addresses of an on-chip page buffer, producing one address per cycle. A page is seen as its main area followed by its spare area. Main-area columns land linearly at the bottom of the buffer. Spare bytes are spread over eight fixed 64-byte slots starting at 0x1000, with one slot for each 512-byte chunk of the page.

A transfer is started with a one-cycle `start` that carries the first column, the byte count, the page-size code, the spare size and a spare-only flag. The block first positions its spare cursor. It then streams addresses over a valid/ready handshake and pulses `done` once the last address has been accepted. A data mover that sits beside it uses these addresses to reach the buffer RAM.

Top module: `nsam_mapper`

## Requirements
- R1: After reset, `addr_valid`, `done` and `busy` are all low.
- R2: When not in spare-only mode, a column c below the page size maps to buffer address c, and successive main-area bytes map to successive addresses.
- R3: The page-size code selects 512 (0), 2048 (1) or 4096 (2 and 3) bytes. The page holds page/512 chunks. Each spare slot uses floor(spare_size / chunks) bytes with bit 0 forced to zero. This value is taken again at every start.
- R4: A spare offset o maps to 0x1000 + s*0x40 + (o - s*slot_bytes), where s = o / slot_bytes, capped at 7.
- R5: Outside spare-only mode, a start column at or above the page size is treated as spare offset (column - page size).
- R6: A transfer that runs past the last main-area column continues at spare offset 0, with no cycle lost when `addr_ready` stays high.
- R7: With `spare_only` high, the start column is used directly as a spare offset.
- R8: Spare bytes past the start of slot 7 stay in slot 7 and are laid out contiguously, even beyond slot_bytes.
- R9: Exactly `byte_cnt` addresses are emitted. `addr_valid` and `addr` hold steady while `addr_ready` is low, and an address is consumed only on a cycle where valid and ready are both high.
- R10: `done` is high for exactly one cycle, the cycle after the last address is accepted. A byte count of zero gives a `done` pulse and no addresses.
- R11: A `start` raised while a transfer is in progress is ignored. The running stream is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only when idle) |
| start_col | input | 13 | First column, or first spare offset in spare-only mode |
| byte_cnt | input | 13 | Number of bytes to map |
| page_sel | input | 2 | Page-size code: 0=512, 1=2048, 2/3=4096 |
| spare_size | input | 8 | Spare-area size in bytes |
| spare_only | input | 1 | Treat start column as a spare offset |
| busy | output | 1 | Transfer in progress |
| addr_valid | output | 1 | `addr` holds a valid buffer address |
| addr_ready | input | 1 | Consumer takes the address this cycle |
| addr | output | 13 | Buffer byte address |
| done | output | 1 | One-cycle pulse after the last address |

## Verification
The hardest case to reach from the ports is spare data that spills past slot_bytes into the capped last slot. This only happens when the spare size does not divide evenly over the chunks. It is reached by a 4096-byte page with a 218-byte spare area, streaming the whole spare area in spare-only mode, so slot 7 takes 36 bytes where the other slots hold 26. A second hard case is a start deep inside the spare area, which makes the cursor seek across several slots before the first address. A third is a run that crosses from the main area into the spare area while `addr_ready` stays high, which shows any lost cycle. Each emitted address is compared against a division-based model in the bench.

// File: rtl/nsam_pkg.sv
package nsam_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } nsam_state_e;

  // log2 of the number of 512-byte chunks for a page-size code
  function automatic logic [1:0] chunk_shift(input logic [1:0] sel);
    logic [1:0] sh;
    case (sel)
      2'd0:    sh = 2'd0;
      2'd1:    sh = 2'd2;
      default: sh = 2'd3;
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/nsam_geom.sv
module nsam_geom #(
  parameter int COL_W       = 13,
  parameter int SPARE_W     = 8,
  parameter int CHUNK_BYTES = 512
) (
  input  logic [1:0]         page_sel,
  input  logic [SPARE_W-1:0] spare_size,
  output logic [COL_W-1:0]   page_bytes,
  output logic [SPARE_W-1:0] slot_bytes
);
  import nsam_pkg::*;

  logic [1:0]         shift_w;
  logic [SPARE_W-1:0] per_chunk;

  always_comb begin
    shift_w    = chunk_shift(page_sel);
    page_bytes = COL_W'(CHUNK_BYTES) << shift_w;
    per_chunk  = spare_size >> shift_w;
    slot_bytes = {per_chunk[SPARE_W-1:1], 1'b0};
  end

endmodule

// File: rtl/nsam_cursor.sv
module nsam_cursor #(
  parameter int COL_W    = 13,
  parameter int SPARE_W  = 8,
  parameter int SLOT_CNT = 8,
  localparam int SLOT_W  = $clog2(SLOT_CNT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [COL_W-1:0]   load_off,
  input  logic [SPARE_W-1:0] load_sb,
  input  logic               seek_en,
  input  logic               run_en,
  input  logic               step,
  output logic [SLOT_W-1:0]  slot,
  output logic [COL_W-1:0]   off,
  output logic               seek_done
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_CNT - 1);

  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [COL_W-1:0]   off_q, off_d;
  logic [SPARE_W-1:0] sb_q, sb_d;
  logic [COL_W-1:0]   sb_ext;
  logic               at_last;

  always_comb begin
    sb_ext    = COL_W'(sb_q);
    at_last   = (slot_q == LAST_SLOT);
    seek_done = at_last || (off_q < sb_ext);
  end

  // next-state
  always_comb begin
    slot_d = slot_q;
    off_d  = off_q;
    sb_d   = sb_q;
    if (load) begin
      slot_d = '0;
      off_d  = load_off;
      sb_d   = load_sb;
    end else if (seek_en && !seek_done) begin
      off_d  = off_q - sb_ext;
      slot_d = slot_q + SLOT_W'(1);
    end else if (step) begin
      if (!at_last && (off_q + COL_W'(1) == sb_ext)) begin
        slot_d = slot_q + SLOT_W'(1);
        off_d  = '0;
      end else begin
        off_d  = off_q + COL_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      off_q  <= '0;
      sb_q   <= '0;
    end else begin
      slot_q <= slot_d;
      off_q  <= off_d;
      sb_q   <= sb_d;
    end
  end

  assign slot = slot_q;
  assign off  = off_q;

  AST_OFF_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !at_last) |-> (off_q < sb_ext)); // R4

  AST_LAST_SLOT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && at_last && step && !load) |=> (slot_q == LAST_SLOT)); // R8

endmodule

// File: rtl/nsam_ctrl.sv
module nsam_ctrl #(
  parameter int COL_W = 13,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [CNT_W-1:0] byte_cnt,
  input  logic             spare_only,
  input  logic [COL_W-1:0] page_bytes,
  input  logic             seek_done,
  input  logic             addr_ready,
  output logic             load,
  output logic [COL_W-1:0] load_off,
  output logic             seek_en,
  output logic             run_en,
  output logic             step_spare,
  output logic             in_main,
  output logic [COL_W-1:0] cur_col,
  output logic [COL_W-1:0] cur_page,
  output logic             last,
  output logic             busy,
  output logic             done
);
  import nsam_pkg::*;

  nsam_state_e      state_q, state_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [COL_W-1:0] page_q, page_d;
  logic             main_q, main_d;
  logic             accept;

  always_comb begin
    load     = (state_q == ST_IDLE) && start;
    seek_en  = (state_q == ST_SEEK);
    run_en   = (state_q == ST_RUN);
    done     = (state_q == ST_FIN);
    busy     = (state_q != ST_IDLE);
    last     = (rem_q == CNT_W'(1));
    accept   = run_en && addr_ready;
    step_spare = accept && !main_q;
    if (spare_only)                load_off = start_col;
    else if (start_col >= page_bytes) load_off = start_col - page_bytes;
    else                           load_off = '0;
  end

  // next-state
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    col_d   = col_q;
    page_d  = page_q;
    main_d  = main_q;
    case (state_q)
      ST_IDLE: if (start) begin
        rem_d   = byte_cnt;
        col_d   = start_col;
        page_d  = page_bytes;
        main_d  = !spare_only && (start_col < page_bytes);
        state_d = (byte_cnt == '0) ? ST_FIN : ST_SEEK;
      end
      ST_SEEK: if (seek_done) state_d = ST_RUN;
      ST_RUN: if (addr_ready) begin
        rem_d = rem_q - CNT_W'(1);
        if (main_q) begin
          if (col_q + COL_W'(1) == page_q) main_d = 1'b0;
          else                             col_d  = col_q + COL_W'(1);
        end
        if (last) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      col_q   <= '0;
      page_q  <= '0;
      main_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      col_q   <= col_d;
      page_q  <= page_d;
      main_q  <= main_d;
    end
  end

  assign in_main  = main_q;
  assign cur_col  = col_q;
  assign cur_page = page_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last) |=> done); // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && start && !(addr_ready && last)) |=> run_en); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !addr_ready) |=> run_en); // R9

endmodule

// File: rtl/nsam_mapper.sv
module nsam_mapper #(
  parameter int COL_W       = 13,
  parameter int CNT_W       = 13,
  parameter int SPARE_W     = 8,
  parameter int ADDR_W      = 13,
  parameter int SLOT_CNT    = 8,
  parameter int SLOT_STRIDE = 64,
  parameter int SPARE_BASE  = 4096,
  parameter int CHUNK_BYTES = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COL_W-1:0]   start_col,
  input  logic [CNT_W-1:0]   byte_cnt,
  input  logic [1:0]         page_sel,
  input  logic [SPARE_W-1:0] spare_size,
  input  logic               spare_only,
  output logic               busy,
  output logic               addr_valid,
  input  logic               addr_ready,
  output logic [ADDR_W-1:0]  addr,
  output logic               done
);

  localparam int SLOT_W    = $clog2(SLOT_CNT);
  localparam int STRIDE_SH = $clog2(SLOT_STRIDE);

  logic [COL_W-1:0]   page_bytes;
  logic [SPARE_W-1:0] slot_bytes;
  logic               load, seek_en, run_en, step_spare, seek_done;
  logic               in_main, last;
  logic [COL_W-1:0]   load_off, cur_col, cur_page;
  logic [SLOT_W-1:0]  slot;
  logic [COL_W-1:0]   off;
  logic [ADDR_W-1:0]  spare_addr;

  nsam_geom #(
    .COL_W(COL_W), .SPARE_W(SPARE_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) geom_i (
    .page_sel(page_sel), .spare_size(spare_size),
    .page_bytes(page_bytes), .slot_bytes(slot_bytes)
  );

  nsam_ctrl #(
    .COL_W(COL_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .byte_cnt(byte_cnt), .spare_only(spare_only), .page_bytes(page_bytes),
    .seek_done(seek_done), .addr_ready(addr_ready), .load(load),
    .load_off(load_off), .seek_en(seek_en), .run_en(run_en),
    .step_spare(step_spare), .in_main(in_main), .cur_col(cur_col),
    .cur_page(cur_page), .last(last), .busy(busy), .done(done)
  );

  nsam_cursor #(
    .COL_W(COL_W), .SPARE_W(SPARE_W), .SLOT_CNT(SLOT_CNT)
  ) cursor_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_off(load_off),
    .load_sb(slot_bytes), .seek_en(seek_en), .run_en(run_en),
    .step(step_spare), .slot(slot), .off(off), .seek_done(seek_done)
  );

  always_comb begin
    spare_addr = ADDR_W'(SPARE_BASE) + (ADDR_W'(slot) << STRIDE_SH) + ADDR_W'(off);
    addr       = in_main ? ADDR_W'(cur_col) : spare_addr;
    addr_valid = run_en;
  end

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready) |=> (addr_valid && $stable(addr))); // R9

  AST_MAIN_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && in_main && !last &&
     (COL_W'(addr) + COL_W'(1) != cur_page))
    |=> (addr_valid && addr == $past(addr) + ADDR_W'(1))); // R2

  AST_CROSS_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && addr_ready && in_main && !last &&
     (COL_W'(addr) + COL_W'(1) == cur_page))
    |=> (addr_valid && !in_main)); // R6

endmodule

// File: tb/nsam_mapper_tb.sv
`timescale 1ns/1ps
module nsam_mapper_tb_top;

  logic        clk, rst_n;
  logic        start, spare_only, addr_ready;
  logic [12:0] start_col, byte_cnt;
  logic [1:0]  page_sel;
  logic [7:0]  spare_size;
  logic        busy, addr_valid, done;
  logic [12:0] addr;

  int checks = 0;
  int errors = 0;

  nsam_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .byte_cnt(byte_cnt), .page_sel(page_sel), .spare_size(spare_size),
    .spare_only(spare_only), .busy(busy), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_addr(input int col, input int psel, input int spare, input bit so);
    int page, chunks, sb, o, s;
    page   = (psel == 0) ? 512 : (psel == 1) ? 2048 : 4096;
    chunks = page / 512;
    sb     = (spare / chunks) & ~1;
    if (!so && col < page) return col;
    o = so ? col : col - page;
    s = (sb == 0) ? 7 : o / sb;
    if (s > 7) s = 7;
    return 4096 + s * 64 + o - s * sb;
  endfunction

  // mode 0: ready always high; mode 1: ready low every third cycle
  task automatic run_xfer(input int col, input int cnt, input int psel, input int spare,
                          input bit so, input int mode, input bit poke, input string req);
    int  k;
    bit  expect_done, seen_first, fin;
    bit  rdy;
    k = 0; seen_first = 0; fin = 0;
    @(negedge clk);
    start_col = 13'(col); byte_cnt = 13'(cnt); page_sel = 2'(psel);
    spare_size = 8'(spare); spare_only = so; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_done = (cnt == 0);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      rdy = (mode == 0) || (cyc % 3 != 2);
      addr_ready = rdy;
      start = poke && (cyc == 4);
      if (start) begin
        start_col = 13'd0; byte_cnt = 13'd3; spare_only = ~so;
      end
      #1;
      if (expect_done) begin
        chk(done == 1'b1, {req, " R10 done after last"}, int'(done), 1);
        chk(addr_valid == 1'b0, {req, " R10 no valid with done"}, int'(addr_valid), 0);
        fin = 1;
        break;
      end
      if (done) chk(1'b0, {req, " R10 early done"}, k, cnt);
      if (addr_valid) begin
        if (k >= cnt) chk(1'b0, {req, " R9 extra address"}, k, cnt);
        else chk(int'(addr) == ref_addr(col + k, psel, spare, so),
                 {req, " address"}, int'(addr), ref_addr(col + k, psel, spare, so));
        seen_first = 1;
        if (rdy) begin
          k++;
          if (k == cnt) expect_done = 1;
        end
      end else if (seen_first && mode == 0 && k < cnt) begin
        chk(1'b0, {req, " R6 gap in stream"}, 0, 1);
      end
      @(negedge clk);
    end
    start = 1'b0;
    addr_ready = 1'b0;
    chk(fin, {req, " R10 transfer finished"}, int'(fin), 1);
    chk(k == cnt, {req, " R9 address count"}, k, cnt);
    @(negedge clk); #1;
    chk(busy == 1'b0 && addr_valid == 1'b0, {req, " R11 idle after done"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    #1;
    chk(addr_valid == 1'b0, "R1 valid low", int'(addr_valid), 0);
    chk(done == 1'b0, "R1 done low", int'(done), 0);
    chk(busy == 1'b0, "R1 busy low", int'(busy), 0);
  endtask

  task automatic t_main_linear;       run_xfer(10, 20, 0, 16, 0, 0, 0, "R2 main 512"); endtask
  task automatic t_main_stall;        run_xfer(300, 25, 1, 64, 0, 1, 0, "R9 main stalled"); endtask
  task automatic t_spare_512;         run_xfer(512, 16, 0, 16, 0, 0, 0, "R5 R4 spare 512/16"); endtask
  task automatic t_cross;             run_xfer(2040, 30, 1, 64, 0, 0, 0, "R6 cross 2048/64"); endtask
  task automatic t_seek_deep;         run_xfer(2048 + 50, 14, 1, 64, 0, 1, 0, "R4 seek 2048/64"); endtask
  task automatic t_spare_only_128;    run_xfer(5, 100, 2, 128, 1, 1, 0, "R7 spare only 4096/128"); endtask
  task automatic t_overflow_218;      run_xfer(0, 218, 2, 218, 1, 0, 0, "R8 overflow 4096/218"); endtask
  task automatic t_code3;             run_xfer(4096 + 40, 30, 3, 128, 0, 0, 0, "R3 code 3 as 4096"); endtask
  task automatic t_zero;              run_xfer(7, 0, 1, 64, 0, 0, 0, "R10 zero count"); endtask
  task automatic t_busy_start;        run_xfer(2030, 40, 1, 64, 0, 1, 1, "R11 start while busy"); endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; spare_only = 1'b0; addr_ready = 1'b0;
    start_col = '0; byte_cnt = '0; page_sel = '0; spare_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_main_linear();
    t_main_stall();
    t_spare_512();
    t_cross();
    t_seek_deep();
    t_spare_only_128();
    t_overflow_218();
    t_code3();
    t_zero();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule